// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

One channel of a word-oriented DMA engine. Software programs a control word, source and destination addresses, a per-trigger word count, a total word count, an interval setting and a fill word through a small register port. The channel then moves 32-bit words in atomic power-of-two blocks. It holds the bus request for the whole of a block and waits a prescaled interval between blocks. Each word is either read at the working source address and written one cycle later at the working destination address, or it is taken from the fill word with no read at all.

A transfer starts in one of three ways. Immediate mode starts the moment the channel is enabled. Repeating mode runs one group per start event and never ends by itself. Counted mode runs one group per start event and disables the channel once a total number of words has been moved. A one-cycle interrupt pulse marks the completion of a group, where the mode calls for one.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the control register reads 0, and `bus_req`, `rd_stb`, `wr_stb` and `irq` are low.
- R2: The register offsets on `reg_addr` are 0 control, 1 source, 2 destination, 3 total count, 4 write count, 5 interval, 6 fill. Address registers read back with bits 1:0 cleared. Control bit 31 is the enable and reads 1 while the channel is active.
- R3: Each word is read at the working source address and written to the working destination address. Both addresses are word aligned. The update codes are: destination bits 11:10, source bits 14:13, with 0 = +4, 1 = -4 and 2 = unchanged. Destination code 3 also leaves the address unchanged.
- R4: Source code 3 selects fill. No read strobe is issued, and every word written carries the fill register value.
- R5: Control bits 19:16 = e give a block of 2^e words, cut short by the words remaining. No read or write strobe comes before the grant. `bus_req` stays high from the grant to the last write of the block.
- R6: The interval register holds the tick count n in bits 15:0 and the prescaler p in bits 17:16. After a block, the next block is requested only after n*4^p cycles. With n = 0 the request follows at once.
- R7: Control bit 28 (immediate) starts a group of write-count words when the enable goes from 0 to 1. The total count and bit 29 are ignored, and the enable clears when the group ends.
- R8: With bit 29 set and bit 28 clear, each start event moves one group of write-count words. The total count is ignored and the enable stays set.
- R9: With bits 28 and 29 clear, each start event moves one group. The total count is loaded when the enable rises. The enable clears as soon as that many words have been written, even in the middle of a group.
- R10: Control bit 15 (source) and bit 12 (destination) reload the working address from the programmed value at the start of each group. Without the flag, the working address continues from where the last group left it.
- R11: `irq` is a one-cycle pulse in the cycle after the final write of a group that clears the enable, or of any group in repeating mode. It only fires if control bit 30 is set.
- R12: A start event is ignored while the channel is disabled or while a group is in progress.
- R13: Writing control bit 31 as 0 stops the channel at once. No further words are moved and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| start_evt | input | 1 | Start event for repeating and counted modes |
| bus_req | output | 1 | Bus request to arbiter |
| bus_gnt | input | 1 | Bus grant from arbiter |
| rd_stb | output | 1 | Word read strobe |
| rd_addr | output | 32 | Word read address |
| rd_data | input | 32 | Read data, valid in the strobe cycle |
| wr_stb | output | 1 | Word write strobe |
| wr_addr | output | 32 | Word write address |
| wr_data | output | 32 | Word write data |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The bench aims at block boundaries. It measures the spacing of writes across a boundary for several prescaler and interval settings, including a zero interval. A miscounted prescaler or an interval that is off by one shows up there as a spacing that is one tick or one cycle wrong. Counted mode is run with a total that is not a multiple of the write count, so that a channel which only stops at group ends makes an extra write, and which raises an interrupt on ordinary group ends shows a wrong pulse count. Repeating mode uses a destination reload with a source that keeps advancing, so a swapped or ignored reload flag gives wrong addresses. The remaining targets are double start events during a busy group, fill mode (any read strobe fails it), and an abort in the middle of a gap: a channel that ignores the abort resumes writing after the gap.

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int WCNT_W = 24,
  parameter int TCNT_W = 28,
  parameter int IVL_W  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        start_evt,
  output logic        bus_req,
  input  logic        bus_gnt,
  output logic        rd_stb,
  output logic [31:0] rd_addr,
  input  logic [31:0] rd_data,
  output logic        wr_stb,
  output logic [31:0] wr_addr,
  output logic [31:0] wr_data,
  output logic        irq
);
  localparam logic [2:0] A_CTRL = 3'd0, A_SRC = 3'd1, A_DST = 3'd2, A_TOT = 3'd3,
                         A_WCNT = 3'd4, A_IVL = 3'd5, A_FILL = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_RD, S_WR, S_GAP} st_t;
  st_t state;

  logic [31:0]         ctrl_q, src_p, dst_p, src_w, dst_w, fill_q, data_q;
  logic [TCNT_W-1:0]   tot_q, tleft;
  logic [WCNT_W-1:0]   wcnt_q, wleft;
  logic [IVL_W+1:0]    ivl_q;
  logic [IVL_W-1:0]    gleft;
  logic [15:0]         bleft;
  logic [5:0]          pre;

  wire [1:0] dmode  = ctrl_q[11:10];
  wire [1:0] smode  = ctrl_q[14:13];
  wire       fill_m = (smode == 2'd3);
  wire       imm    = ctrl_q[28];
  wire       rpt    = ~ctrl_q[28] & ctrl_q[29];
  wire       cnted  = ~ctrl_q[28] & ~ctrl_q[29];
  wire [1:0] psc    = ivl_q[IVL_W +: 2];
  wire [IVL_W-1:0] ivl = ivl_q[IVL_W-1:0];
  wire [5:0] pre_top = 6'((7'd1 << {psc, 1'b0}) - 7'd1);

  wire ctl_wr   = reg_we && (reg_addr == A_CTRL);
  wire en_rise  = ctl_wr && reg_wdata[31] && !ctrl_q[31];
  wire go_imm   = en_rise && reg_wdata[28];
  wire go_evt   = start_evt && ctrl_q[31] && !imm && (state == S_IDLE) && !ctl_wr;
  wire last_grp = (wleft == WCNT_W'(1));
  wire last_tot = cnted && (tleft == TCNT_W'(1));
  wire ends     = imm || last_tot;

  function automatic logic [31:0] step(input logic [31:0] a, input logic [1:0] m);
    case (m)
      2'd0:    return a + 32'd4;
      2'd1:    return a - 32'd4;
      default: return a;
    endcase
  endfunction

  assign bus_req = (state == S_REQ) || (state == S_RD) || (state == S_WR);
  assign rd_stb  = (state == S_RD);
  assign wr_stb  = (state == S_WR);
  assign rd_addr = src_w;
  assign wr_addr = dst_w;
  assign wr_data = fill_m ? fill_q : data_q;

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_SRC:   reg_rdata = src_p;
      A_DST:   reg_rdata = dst_p;
      A_TOT:   reg_rdata = 32'(tot_q);
      A_WCNT:  reg_rdata = 32'(wcnt_q);
      A_IVL:   reg_rdata = 32'(ivl_q);
      A_FILL:  reg_rdata = fill_q;
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ctrl_q <= '0; src_p <= '0; dst_p <= '0; src_w <= '0; dst_w <= '0;
      fill_q <= '0; data_q <= '0; tot_q <= '0; tleft <= '0; wcnt_q <= '0;
      wleft <= '0; ivl_q <= '0; gleft <= '0; bleft <= '0; pre <= '0;
      irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (state)
        S_IDLE: if (go_evt) begin
          wleft <= wcnt_q;
          if (ctrl_q[15]) src_w <= src_p;
          if (ctrl_q[12]) dst_w <= dst_p;
          if (wcnt_q != '0) state <= S_REQ;
        end
        S_REQ: if (bus_gnt) begin
          bleft <= 16'd1 << ctrl_q[19:16];
          state <= fill_m ? S_WR : S_RD;
        end
        S_RD: begin
          data_q <= rd_data;
          src_w  <= step(src_w, smode);
          state  <= S_WR;
        end
        S_WR: begin
          dst_w <= step(dst_w, dmode);
          wleft <= wleft - WCNT_W'(1);
          bleft <= bleft - 16'd1;
          if (cnted) tleft <= tleft - TCNT_W'(1);
          if (last_grp || last_tot) begin
            state <= S_IDLE;
            irq   <= ctrl_q[30] && (ends || rpt);
            if (ends) ctrl_q[31] <= 1'b0;
          end else if (bleft == 16'd1) begin
            if (ivl == '0) state <= S_REQ;
            else begin
              state <= S_GAP;
              gleft <= ivl;
              pre   <= '0;
            end
          end else begin
            state <= fill_m ? S_WR : S_RD;
          end
        end
        S_GAP: begin
          if (pre == pre_top) begin
            pre   <= '0;
            gleft <= gleft - IVL_W'(1);
            if (gleft == IVL_W'(1)) state <= S_REQ;
          end else begin
            pre <= pre + 6'd1;
          end
        end
        default: state <= S_IDLE;
      endcase

      if (en_rise) tleft <= tot_q;
      if (go_imm) begin
        wleft <= wcnt_q;
        if (reg_wdata[15]) src_w <= src_p;
        if (reg_wdata[12]) dst_w <= dst_p;
        if (wcnt_q != '0) state <= S_REQ;
      end

      if (reg_we) begin
        case (reg_addr)
          A_CTRL: begin
            ctrl_q <= reg_wdata;
            if (!reg_wdata[31]) state <= S_IDLE;
            if (go_imm && wcnt_q == '0) ctrl_q[31] <= 1'b0;
          end
          A_SRC:  begin src_p <= {reg_wdata[31:2], 2'b00}; src_w <= {reg_wdata[31:2], 2'b00}; end
          A_DST:  begin dst_p <= {reg_wdata[31:2], 2'b00}; dst_w <= {reg_wdata[31:2], 2'b00}; end
          A_TOT:  tot_q  <= reg_wdata[TCNT_W-1:0];
          A_WCNT: wcnt_q <= reg_wdata[WCNT_W-1:0];
          A_IVL:  ivl_q  <= reg_wdata[IVL_W+1:0];
          A_FILL: fill_q <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  p_irq_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_req_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> ($past(wr_stb) || $past(reg_we)));

  p_first_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_stb || wr_stb) && !$past(rd_stb || wr_stb)) |-> $past(bus_gnt));

  p_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb |-> rd_addr[1:0] == 2'b00) and (wr_stb |-> wr_addr[1:0] == 2'b00));
endmodule

// File: tb/test_dma_chan_seq.sv
module test_dma_chan_seq;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0, start_evt = 1'b0, bus_gnt = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata, rd_addr, rd_data, wr_addr, wr_data;
  logic        bus_req, rd_stb, wr_stb, irq;

  dma_chan_seq i_dma_chan_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start_evt(start_evt),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq));

  always #5 clk = ~clk;
  always @(posedge clk) bus_gnt <= rst_n & bus_req;
  assign rd_data = {rd_addr[15:0], ~rd_addr[15:0]};

  function automatic logic [31:0] dat(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  logic [63:0] exp_q[$];
  int wtimes[$];
  int cyc = 0, rd_cnt = 0, irq_cnt = 0, nerr = 0, nchk = 0;
  string cur_req = "R3";
  logic [31:0] rv;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (rd_stb) rd_cnt++;
    if (irq) irq_cnt++;
    if (wr_stb) begin
      wtimes.push_back(cyc);
      if (exp_q.size() == 0) check(1'b0, cur_req, "unexpected write", {wr_addr, wr_data}, 64'd0);
      else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        check({wr_addr, wr_data} == e, cur_req, "write addr/data", {wr_addr, wr_data}, e);
      end
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic evt();
    @(negedge clk); start_evt = 1'b1;
    @(negedge clk); start_evt = 1'b0;
  endtask

  task automatic push(input logic [31:0] a, input logic [31:0] d);
    exp_q.push_back({a, d});
  endtask

  task automatic clear();
    wtimes.delete(); rd_cnt = 0; irq_cnt = 0;
  endtask

  task automatic settle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !bus_req) break;
    end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, cur_req, "writes still pending", 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    #2_000_000;
    nerr++; nchk++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_reg(3'd0, rv);
    check(rv == 32'd0, "R1", "ctrl after reset", 64'(rv), 64'd0);
    check(!bus_req && !rd_stb && !wr_stb && !irq, "R1", "outputs after reset",
          64'({bus_req, rd_stb, wr_stb, irq}), 64'd0);

    // R2 readback and alignment
    wr_reg(3'd1, 32'h0000_2003);
    rd_reg(3'd1, rv);
    check(rv == 32'h0000_2000, "R2", "source readback aligned", 64'(rv), 64'h2000);
    wr_reg(3'd6, 32'h1234_5678);
    rd_reg(3'd6, rv);
    check(rv == 32'h1234_5678, "R2", "fill readback", 64'(rv), 64'h12345678);

    // R7 immediate, R5 2-word blocks, R6 gap of 2 cycles, total and repeat ignored
    cur_req = "R7"; clear();
    wr_reg(3'd1, 32'h100); wr_reg(3'd2, 32'h800);
    wr_reg(3'd4, 32'd5); wr_reg(3'd3, 32'd1); wr_reg(3'd5, 32'd2);
    for (int i = 0; i < 5; i++) push(32'h800 + 32'(4*i), dat(32'h100 + 32'(4*i)));
    wr_reg(3'd0, 32'hF001_0000);
    rd_reg(3'd0, rv);
    check(rv[31] == 1'b1, "R2", "busy while running", 64'(rv[31]), 64'd1);
    settle();
    check(wtimes.size() == 5, "R7", "immediate word count", 64'(wtimes.size()), 64'd5);
    if (wtimes.size() == 5) begin
      check(wtimes[1] - wtimes[0] == 2, "R5", "spacing inside block", 64'(wtimes[1] - wtimes[0]), 64'd2);
      check(wtimes[2] - wtimes[1] == 6, "R6", "spacing across gap n=2 p=0", 64'(wtimes[2] - wtimes[1]), 64'd6);
      check(wtimes[4] - wtimes[3] == 6, "R5", "short last block after gap", 64'(wtimes[4] - wtimes[3]), 64'd6);
    end
    rd_reg(3'd0, rv);
    check(rv[31] == 1'b0, "R7", "enable cleared at end", 64'(rv[31]), 64'd0);
    check(irq_cnt == 1, "R11", "one irq pulse", 64'(irq_cnt), 64'd1);

    // R3 decrement source, fixed destination, irq disabled
    cur_req = "R3"; clear();
    wr_reg(3'd1, 32'h300); wr_reg(3'd2, 32'h900);
    wr_reg(3'd4, 32'd3); wr_reg(3'd5, 32'd0);
    push(32'h900, dat(32'h300)); push(32'h900, dat(32'h2FC)); push(32'h900, dat(32'h2F8));
    wr_reg(3'd0, 32'h9003_2800);
    settle();
    check(irq_cnt == 0, "R11", "no irq when disabled", 64'(irq_cnt), 64'd0);

    // R4 fill mode
    cur_req = "R4"; clear();
    wr_reg(3'd2, 32'hA00); wr_reg(3'd6, 32'hDEAD_BEEF); wr_reg(3'd4, 32'd4);
    for (int i = 0; i < 4; i++) push(32'hA00 + 32'(4*i), 32'hDEAD_BEEF);
    wr_reg(3'd0, 32'hD002_6000);
    settle();
    check(rd_cnt == 0, "R4", "no reads in fill mode", 64'(rd_cnt), 64'd0);
    if (wtimes.size() == 4)
      check(wtimes[3] - wtimes[0] == 3, "R4", "fill burst back to back", 64'(wtimes[3] - wtimes[0]), 64'd3);

    // R12 event while disabled, R9 counted mode, R10 continuing addresses
    cur_req = "R12"; clear();
    wr_reg(3'd0, 32'h0);
    evt();
    repeat (20) @(negedge clk);
    check(wtimes.size() == 0, "R12", "event ignored when disabled", 64'(wtimes.size()), 64'd0);
    cur_req = "R9";
    wr_reg(3'd1, 32'h400); wr_reg(3'd2, 32'hC00);
    wr_reg(3'd4, 32'd2); wr_reg(3'd3, 32'd5); wr_reg(3'd5, 32'd0);
    wr_reg(3'd0, 32'hC004_0000);
    push(32'hC00, dat(32'h400)); push(32'hC04, dat(32'h404));
    evt(); evt();
    settle();
    check(wtimes.size() == 2, "R12", "event ignored while busy", 64'(wtimes.size()), 64'd2);
    push(32'hC08, dat(32'h408)); push(32'hC0C, dat(32'h40C));
    evt(); settle();
    check(irq_cnt == 0, "R11", "no irq on plain group end", 64'(irq_cnt), 64'd0);
    rd_reg(3'd0, rv);
    check(rv[31] == 1'b1, "R9", "still enabled before total", 64'(rv[31]), 64'd1);
    push(32'hC10, dat(32'h410));
    evt(); settle();
    check(wtimes.size() == 5, "R9", "stops mid group at total", 64'(wtimes.size()), 64'd5);
    rd_reg(3'd0, rv);
    check(rv[31] == 1'b0, "R9", "enable cleared at total", 64'(rv[31]), 64'd0);
    check(irq_cnt == 1, "R11", "irq at total", 64'(irq_cnt), 64'd1);
    evt();
    repeat (20) @(negedge clk);
    check(wtimes.size() == 5, "R12", "event ignored after finish", 64'(wtimes.size()), 64'd5);

    // R8 repeating mode, R10 destination reload with source continuing
    cur_req = "R10"; clear();
    wr_reg(3'd1, 32'h500); wr_reg(3'd2, 32'hE00);
    wr_reg(3'd4, 32'd2); wr_reg(3'd3, 32'd1);
    wr_reg(3'd0, 32'hE004_1000);
    for (int k = 0; k < 3; k++) begin
      push(32'hE00, dat(32'h500 + 32'(8*k)));
      push(32'hE04, dat(32'h504 + 32'(8*k)));
      evt(); settle();
    end
    check(irq_cnt == 3, "R8", "irq per repeating group", 64'(irq_cnt), 64'd3);
    rd_reg(3'd0, rv);
    check(rv[31] == 1'b1, "R8", "stays enabled", 64'(rv[31]), 64'd1);
    wr_reg(3'd0, 32'h0);

    // R6 prescaler and zero interval spacing
    cur_req = "R6";
    for (int t = 0; t < 3; t++) begin
      int exp_d;
      clear();
      wr_reg(3'd1, 32'h600); wr_reg(3'd2, 32'hF00); wr_reg(3'd4, 32'd2);
      if (t == 0) begin wr_reg(3'd5, 32'h0001_0003); exp_d = 16; end
      else if (t == 1) begin wr_reg(3'd5, 32'h0003_0001); exp_d = 68; end
      else begin wr_reg(3'd5, 32'h0); exp_d = 3; end
      push(32'hF00, dat(32'h600)); push(32'hF04, dat(32'h604));
      wr_reg(3'd0, 32'h9000_0000);
      settle();
      if (wtimes.size() == 2)
        check(wtimes[1] - wtimes[0] == exp_d, "R6", "block spacing", 64'(wtimes[1] - wtimes[0]), 64'(exp_d));
      else check(1'b0, "R6", "word count", 64'(wtimes.size()), 64'd2);
    end

    // R13 abort during gap
    cur_req = "R13"; clear();
    wr_reg(3'd1, 32'h700); wr_reg(3'd2, 32'h1700);
    wr_reg(3'd4, 32'd8); wr_reg(3'd5, 32'h0003_0004);
    wr_reg(3'd0, 32'hE000_0000);
    push(32'h1700, dat(32'h700));
    evt();
    for (int i = 0; i < 100 && wtimes.size() == 0; i++) @(negedge clk);
    wr_reg(3'd0, 32'h0);
    repeat (300) @(negedge clk);
    check(wtimes.size() == 1, "R13", "no words after abort", 64'(wtimes.size()), 64'd1);
    check(!bus_req, "R13", "request dropped", 64'(bus_req), 64'd0);
    check(irq_cnt == 0, "R13", "no irq on abort", 64'(irq_cnt), 64'd0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule